// File: doc/BRIEF.md
# Sliding-Window Survivor Traceback Unit

This block sits behind the add-compare-select stage of a radix-4 Viterbi decoder. Each accepted input word holds the survivor decisions of two trellis stages for every state. The words are stored in two window banks used in alternation. A window is REL_STEPS reliable steps followed by CONV_STEPS convergent steps. The convergent steps of one window are also the first steps of the next window, so they are written into both banks at once.

When the last word of a window arrives, a traceback engine walks that bank from its last address down to address 0. It starts from state 0, or from a supplied best state. Steps in the convergent part only steer the state. Steps in the reliable part push decoded pairs into a small LIFO, which then drains them in time order. While the engine works on one bank, the producer keeps filling the other bank with reliable steps. It is held off only when it reaches a convergent step that would overwrite the bank still being read.

The parameters must satisfy 2 <= STATE_BITS and 1 <= CONV_STEPS <= REL_STEPS.

Top module: `slide_win_traceback`

## Requirements
- R1: After synchronous reset, in_ready is 1 and out_valid is 0.
- R2: Decision word layout: bits [2s+1:2s] of in_dec hold the decision pair p for state s. Going back one step from state s gives the predecessor state ((s << 2) | p) mod 2^STATE_BITS.
- R3: Window n is made of accepted words nR .. nR+R+C-1, where R = REL_STEPS and C = CONV_STEPS. After its last word is accepted, window n yields exactly R output pairs, one for each of steps nR .. nR+R-1. The pair for a step is bits [STATE_BITS-1:STATE_BITS-2] of the traceback state at the end of that step.
- R4: No pair is output for convergent steps, so every window produces exactly R out_valid pulses.
- R5: Traceback starts from in_best_state if in_best_en is 1 together with the window's last accepted word, and from state 0 otherwise.
- R6: While a window is being traced back, words that fall in the reliable part of the next window are still accepted.
- R7: in_ready is 0 when the next word falls in a convergent part (position >= R within its window) and traceback or draining of the previous window has not finished. At no other time is in_ready 0.
- R8: Convergent words are stored in both banks, so the next window decodes correctly from words accepted while the previous window was still open.
- R9: Within a window, pairs come out in time order, earliest step first, through a LIFO of depth R.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decision word offered |
| in_ready | output | 1 | Decision word can be taken |
| in_dec | input | 2*2^STATE_BITS | Decision pairs for all states, two stages |
| in_best_en | input | 1 | Use in_best_state as traceback start for this window |
| in_best_state | input | STATE_BITS | Best-metric state at window end |
| out_valid | output | 1 | Decoded pair valid |
| out_pair | output | 2 | Decoded pair, bits [1:0] = state bits [top:top-1] |

## Verification
The hardest situation to reach is the producer hitting the dual-write convergent section while the previous bank is still being traced or drained. The stall arises only when input runs ahead of traceback. The bench feeds words back to back for long stretches, so that each window's R words arrive faster than the 2R+C cycles of traceback plus drain. It checks that every stall falls on a convergent position and that words are accepted while results are still pending. In a second phase, off-path decisions are random and the exact best state is supplied, so correct output depends on the start state and on the shared convergent words.

// File: rtl/swtb_pkg.sv
package swtb_pkg;

    typedef enum logic [1:0] {
        TB_IDLE  = 2'd0,
        TB_TRACE = 2'd1,
        TB_DRAIN = 2'd2
    } tb_phase_e;

    // predecessor state: shift decision pair into low end, keep 'bits' bits
    function automatic logic [31:0] sw_pred(input logic [31:0] s,
                                            input logic [1:0]  p,
                                            input int          bits);
        logic [31:0] mask;
        mask = (32'd1 << bits) - 32'd1;
        return ((s << 2) | {30'd0, p}) & mask;
    endfunction

endpackage

// File: rtl/sw_surv_banks.sv
module sw_surv_banks #(
    parameter int WIN   = 12,
    parameter int DEC_W = 32,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic [DEC_W-1:0] wr_data,
    input  logic             pri_en,
    input  logic             pri_bank,
    input  logic [AW-1:0]    pri_addr,
    input  logic             dup_en,
    input  logic             dup_bank,
    input  logic [AW-1:0]    dup_addr,
    input  logic             rd_bank,
    input  logic [AW-1:0]    rd_addr,
    output logic [DEC_W-1:0] rd_word
);
    logic [DEC_W-1:0] bank_rd [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [DEC_W-1:0] mem [WIN];
        always_ff @(posedge clk) begin
            if (pri_en && (pri_bank == 1'(b)))
                mem[pri_addr] <= wr_data;
            if (dup_en && (dup_bank == 1'(b)))
                mem[dup_addr] <= wr_data;
        end
        assign bank_rd[b] = mem[rd_addr];
    end

    assign rd_word = bank_rd[rd_bank];
endmodule

// File: rtl/sw_write_ctrl.sv
module sw_write_ctrl #(
    parameter int REL = 8,
    parameter int CONV = 4,
    parameter int SB = 4,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_best_en,
    input  logic [SB-1:0] in_best_state,
    input  logic          tb_busy,
    output logic          pri_en,
    output logic          pri_bank,
    output logic [AW-1:0] pri_addr,
    output logic          dup_en,
    output logic          dup_bank,
    output logic [AW-1:0] dup_addr,
    output logic          tb_start,
    output logic          tb_bank,
    output logic [SB-1:0] tb_state
);
    localparam int WIN = REL + CONV;

    logic [AW-1:0] wpos;
    logic          wbank;
    logic          in_conv, accept, last;

    assign in_conv  = (wpos >= AW'(REL));
    assign in_ready = !(in_conv && tb_busy);
    assign accept   = in_valid && in_ready;
    assign last     = (wpos == AW'(WIN - 1));

    assign pri_en   = accept;
    assign pri_bank = wbank;
    assign pri_addr = wpos;
    assign dup_en   = accept && in_conv;
    assign dup_bank = !wbank;
    assign dup_addr = wpos - AW'(REL);

    assign tb_start = accept && last;
    assign tb_bank  = wbank;
    assign tb_state = in_best_en ? in_best_state : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            wpos  <= '0;
            wbank <= 1'b0;
        end else if (accept) begin
            if (last) begin
                wpos  <= AW'(CONV);
                wbank <= !wbank;
            end else begin
                wpos <= wpos + 1'b1;
            end
        end
    end

    // R7: a convergent write must wait for the previous traceback
    p_stall_conv_r7: assert property (@(posedge clk) disable iff (rst)
        (in_conv && tb_busy) |-> !in_ready);
    // R6: reliable positions never stall
    p_ready_rel_r6: assert property (@(posedge clk) disable iff (rst)
        !in_conv |-> in_ready);
    // R7: a window can only end when the engine is free
    p_start_idle_r7: assert property (@(posedge clk) disable iff (rst)
        tb_start |-> !tb_busy);
endmodule

// File: rtl/sw_pair_lifo.sv
module sw_pair_lifo #(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  logic [1:0] din,
    input  logic       pop,
    output logic [1:0] dout,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [1:0] stk [DEPTH];

    assign dout = stk[IW'(count - CW'(1))];

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (push) begin
            stk[IW'(count)] <= din;
            count           <= count + CW'(1);
        end else if (pop) begin
            count <= count - CW'(1);
        end
    end

    // R9: depth R never exceeded, never popped empty
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        push |-> (count < CW'(DEPTH)));
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0));
    p_no_both_r9: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));
endmodule

// File: rtl/sw_traceback.sv
module sw_traceback
    import swtb_pkg::*;
#(
    parameter int REL = 8,
    parameter int CONV = 4,
    parameter int SB = 4,
    parameter int AW = 4,
    parameter int DEC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_bank,
    input  logic [SB-1:0]    start_state,
    output logic             busy,
    output logic             rd_bank,
    output logic [AW-1:0]    rd_addr,
    input  logic [DEC_W-1:0] rd_word,
    output logic             out_valid,
    output logic [1:0]       out_pair
);
    localparam int WIN = REL + CONV;
    localparam int CW  = $clog2(REL + 1);

    tb_phase_e     phase;
    logic [SB-1:0] st;
    logic [1:0]    pair;
    logic          push, pop;
    logic [CW-1:0] fill;

    assign busy = (phase != TB_IDLE);
    assign pair = rd_word[2*int'(st) +: 2];
    assign push = (phase == TB_TRACE) && (rd_addr < AW'(REL));
    assign pop  = (phase == TB_DRAIN);
    assign out_valid = pop;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= TB_IDLE;
            st      <= '0;
            rd_addr <= '0;
            rd_bank <= 1'b0;
        end else begin
            case (phase)
                TB_IDLE: if (start) begin
                    rd_bank <= start_bank;
                    st      <= start_state;
                    rd_addr <= AW'(WIN - 1);
                    phase   <= TB_TRACE;
                end
                TB_TRACE: begin
                    st <= SB'(sw_pred(32'(st), pair, SB));
                    if (rd_addr == '0) phase <= TB_DRAIN;
                    else               rd_addr <= rd_addr - 1'b1;
                end
                TB_DRAIN: if (fill == CW'(1)) phase <= TB_IDLE;
                default: phase <= TB_IDLE;
            endcase
        end
    end

    sw_pair_lifo #(.DEPTH(REL)) lifo_i (
        .clk(clk), .rst(rst),
        .push(push), .din(st[SB-1 -: 2]),
        .pop(pop), .dout(out_pair), .count(fill)
    );

    // R3: traceback ends at address 0 and hands over to draining
    p_trace_exit_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == TB_TRACE && rd_addr == '0) |=> (phase == TB_DRAIN));
    // R4: draining starts with a full LIFO of R pairs
    p_drain_full_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(phase == TB_DRAIN) |-> (fill == CW'(REL)));
endmodule

// File: rtl/slide_win_traceback.sv
module slide_win_traceback #(
    parameter int STATE_BITS = 4,
    parameter int REL_STEPS  = 8,
    parameter int CONV_STEPS = 4,
    localparam int NSTATE = 1 << STATE_BITS,
    localparam int DEC_W  = 2 * NSTATE
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [DEC_W-1:0]      in_dec,
    input  logic                  in_best_en,
    input  logic [STATE_BITS-1:0] in_best_state,
    output logic                  out_valid,
    output logic [1:0]            out_pair
);
    localparam int WIN = REL_STEPS + CONV_STEPS;
    localparam int AW  = $clog2(WIN);

    logic                  pri_en, pri_bank, dup_en, dup_bank;
    logic [AW-1:0]         pri_addr, dup_addr, rd_addr;
    logic                  tb_start, tb_bank, tb_busy, rd_bank;
    logic [STATE_BITS-1:0] tb_state;
    logic [DEC_W-1:0]      rd_word;

    sw_write_ctrl #(.REL(REL_STEPS), .CONV(CONV_STEPS), .SB(STATE_BITS), .AW(AW)) wctl_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_best_en(in_best_en), .in_best_state(in_best_state), .tb_busy(tb_busy),
        .pri_en(pri_en), .pri_bank(pri_bank), .pri_addr(pri_addr),
        .dup_en(dup_en), .dup_bank(dup_bank), .dup_addr(dup_addr),
        .tb_start(tb_start), .tb_bank(tb_bank), .tb_state(tb_state)
    );

    sw_surv_banks #(.WIN(WIN), .DEC_W(DEC_W), .AW(AW)) banks_i (
        .clk(clk), .wr_data(in_dec),
        .pri_en(pri_en), .pri_bank(pri_bank), .pri_addr(pri_addr),
        .dup_en(dup_en), .dup_bank(dup_bank), .dup_addr(dup_addr),
        .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_word(rd_word)
    );

    sw_traceback #(.REL(REL_STEPS), .CONV(CONV_STEPS), .SB(STATE_BITS),
                   .AW(AW), .DEC_W(DEC_W)) tb_i (
        .clk(clk), .rst(rst), .start(tb_start), .start_bank(tb_bank),
        .start_state(tb_state), .busy(tb_busy), .rd_bank(rd_bank),
        .rd_addr(rd_addr), .rd_word(rd_word),
        .out_valid(out_valid), .out_pair(out_pair)
    );

    // R8: the duplicate write never lands in the bank under traceback
    p_dup_safe_r8: assert property (@(posedge clk) disable iff (rst)
        (dup_en && tb_busy) |-> (dup_bank != rd_bank));
endmodule

// File: tb/slide_win_traceback_tb_top.sv
module slide_win_traceback_tb_top;
    localparam int SB = 4;
    localparam int R = 8;
    localparam int C = 4;
    localparam int WIN = R + C;
    localparam int NS = 1 << SB;
    localparam int DW = 2 * NS;
    localparam int NSTEP = 100;
    localparam int SPLIT = 48;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [DW-1:0] in_dec = '0;
    logic in_best_en = 1'b0;
    logic [SB-1:0] in_best_state = '0;
    logic out_valid;
    logic [1:0] out_pair;

    always #2 clk = ~clk;

    slide_win_traceback #(.STATE_BITS(SB), .REL_STEPS(R), .CONV_STEPS(C)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_dec(in_dec), .in_best_en(in_best_en), .in_best_state(in_best_state),
        .out_valid(out_valid), .out_pair(out_pair)
    );

    int checks = 0;
    int fails = 0;
    int outs = 0;
    int stalls = 0;
    int overlap = 0;
    bit done = 0;

    logic [1:0]    bpair [NSTEP];
    logic [SB-1:0] tst   [NSTEP];
    logic [DW-1:0] dec   [NSTEP];
    logic [1:0]    exp_q [$];
    bit            exp_best [$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit is_end(input int k);
        return (k >= WIN - 1) && (((k - (WIN - 1)) % R) == 0);
    endfunction

    function automatic int pos_of(input int k);
        return (k < WIN) ? k : C + ((k - WIN) % R);
    endfunction

    // monitor: compare each output against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                outs++;
                if (exp_q.size() == 0) begin
                    check(0, "R4 unexpected output", int'(out_pair), -1);
                end else begin
                    logic [1:0] e;
                    bit b;
                    e = exp_q.pop_front();
                    b = exp_best.pop_front();
                    if (b) check(out_pair == e, "R5 R2 R3 R8 R9 best-start pair", int'(out_pair), int'(e));
                    else   check(out_pair == e, "R2 R3 R8 R9 zero-start pair", int'(out_pair), int'(e));
                end
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(0, "watchdog", 0, 1);
            finish_run();
        end
    end

    initial begin
        logic [SB-1:0] prev;
        prev = '0;
        for (int k = 0; k < NSTEP; k++) begin
            bpair[k] = 2'($urandom);
            tst[k] = SB'(({30'd0, bpair[k]} << (SB - 2)) | (32'(prev) >> 2));
            for (int s = 0; s < NS; s++) begin
                if (k < SPLIT || s == int'(tst[k])) dec[k][2*s +: 2] = prev[1:0];
                else                                 dec[k][2*s +: 2] = 2'($urandom);
            end
            prev = tst[k];
        end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);

        for (int k = 0; k < NSTEP; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_dec = dec[k];
            in_best_en = is_end(k) && (k >= SPLIT);
            in_best_state = tst[k];
            while (!in_ready) begin
                stalls++;
                check(pos_of(k) >= R, "R7 stall only at convergent position", pos_of(k), R);
                @(negedge clk);
            end
            @(posedge clk);
            if (exp_q.size() > 0) overlap++;
            if (is_end(k)) begin
                int n;
                n = (k - (WIN - 1)) / R;
                for (int i = 0; i < R; i++) begin
                    exp_q.push_back(bpair[n*R + i]);
                    exp_best.push_back(k >= SPLIT);
                end
            end
            if (k < SPLIT && (k % 5) == 3) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_best_en = 1'b0;
        repeat (120) @(negedge clk);

        check(exp_q.size() == 0, "R4 all expected pairs produced", exp_q.size(), 0);
        check(outs == ((NSTEP - WIN) / R + 1) * R, "R3 R4 output count", outs,
              ((NSTEP - WIN) / R + 1) * R);
        check(stalls > 0, "R7 stall reached", stalls, 1);
        check(overlap > 0, "R6 accept during pending traceback", overlap, 1);
        check(in_ready == 1'b1, "R7 ready when idle", int'(in_ready), 1);
        done = 1;
        finish_run();
    end
endmodule